// File: doc/BRIEF.md
# Configurable Product-Term Logic Cell

This block is one logic cell of a programmable logic fabric. Five product terms come from an array that lies outside the block. A configuration word gives each term a job: it can join the cell's OR sum, or it can drive a control such as the clock, clock enable, clear, set, output enable, the second operand of the polarity XOR, or a separate register data input. An incoming sum from a neighbouring cell can be ORed into the local sum, and the combined sum leaves as the cascade output. Cells can therefore be chained, and a chain of eight cells builds a sum of up to 40 terms.

The storage element works as a D, T, JK or SR flip-flop, or as a latch that is transparent while its clock is high. Its clock is one of the global clocks or a product term. When a global clock is in use, a product-term clock enable can block clock edges. The pin output and the buried feedback each choose, on their own, between the combinational XOR result and the stored value. An inverted copy of one chosen term leaves as the foldback output.

All global clock and product-term clock inputs are level signals. The block samples them on the fabric clock `clk_i`, so a source "edge" is a rise seen between two consecutive `clk_i` cycles. A stored value becomes visible at the outputs on the cycle after that rise. Clear and set act on the outputs in the same cycle they are asserted and force the stored value on the next `clk_i` edge.

Top module: `pterm_macrocell`

## Requirements
- R1: `casc_o` is the OR of every `pt_i[n]` whose bit `n` is set in the sum mask, combined in the same cycle.
- R2: With the cascade enable set, `casc_i` is ORed into the sum. With the enable clear, `casc_i` has no effect on `casc_o`.
- R3: The combinational result is the sum XOR a second operand. XOR mode code 0 gives constant 0, code 1 gives constant 1, and codes 2 and 3 give `pt_i[xor index]`.
- R4: Register data source code 0 (and 3) takes the XOR result, code 1 takes `pt_i[data index]`, and code 2 takes `pin_i`.
- R5: Storage mode code 0 (D) loads the data on a rising edge of the selected clock. Mode code 1 (T) inverts the stored value on that edge when the data is 1. Mode codes 5 to 7 act as D.
- R6: In mode code 2 (JK) and mode code 3 (SR), J or S is the data and K or R is `pt_i[K index]`. JK holds on 00, clears on 01, sets on 10 and toggles on 11. SR clears whenever R is 1, otherwise sets when S is 1 and holds when S is 0.
- R7: In mode code 4 (latch), the stored value follows the data on every `clk_i` cycle in which the selected clock level is high and enabled, and holds while the level is low.
- R8: Clock select codes 0 to 2 pick `gclk_i[code]`, and code 3 picks `pt_i[clock index]`. With a global clock and the clock enable bit set, clock edges (and latch transparency) are ignored while `pt_i[enable index]` is 0. With the product-term clock, the enable has no effect.
- R9: Clear mode code 0 disables the clear, 1 uses `gclr_i`, 2 uses `pt_i[clear index]`, and 3 uses the OR of both. The set is `pt_i[set index]` when the set enable bit is on. Clear forces the stored value to 0 and set forces it to 1, visibly in the same cycle. Clear wins when both are asserted.
- R10: The register select bit picks the stored value for `pin_o`, otherwise the combinational result. The feedback select bit makes the same choice for `fb_o`, independently of the pin output.
- R11: OE mode code 0 drives `oe_o` to 1, code 1 drives it to 0, and codes 2 and 3 drive it to `pt_i[oe index]`. `fold_o` is the inverse of `pt_i[fold index]`.
- R12: While `rst_ni` is low, the stored value and all clock history are 0. Any term index at or above five reads as constant 0.
- R13: The configuration word, from bit 0 upward, holds: sum mask[4:0], cascade enable[5], XOR mode[7:6], XOR index[10:8], data source[12:11], data index[15:13], K index[18:16], storage mode[21:19], clock select[23:22], clock index[26:24], enable bit[27], enable index[30:28], clear mode[32:31], clear index[35:33], set enable[36], set index[39:37], pin register select[40], feedback register select[41], OE mode[43:42], OE index[46:44], fold index[49:47].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fabric clock that samples every clock source |
| rst_ni | input | 1 | Active-low asynchronous power-up reset |
| cfg_i | input | 50 | Configuration word (layout in R13) |
| pt_i | input | 5 | Product-term inputs |
| casc_i | input | 1 | Cascade sum from the neighbouring cell |
| gclk_i | input | 3 | Global clock levels |
| gclr_i | input | 1 | Global clear |
| pin_i | input | 1 | Value read back from the cell's pad |
| pin_o | output | 1 | Pin output data |
| oe_o | output | 1 | Pin output enable |
| fb_o | output | 1 | Buried feedback |
| casc_o | output | 1 | Cascade sum to the next cell |
| fold_o | output | 1 | Inverted foldback term |

## Verification
The bench aims at the points where storage modes and control sources interact. These include a JK input of 11 that must toggle, an SR input of 11 that must clear, and a clock enable that must block edges on a global clock but be ignored on a product-term clock. It also covers clear and set arriving in the same cycle, where a design that gave set priority would drive a 1 out of a cleared cell. Out-of-range term indices must read as 0 rather than aliasing onto a real term. The latch must follow its data for the whole high level, not only at the rise. Pin and feedback selects are driven to opposite settings, so a design that tied them together shows a mismatch on one of the two outputs.

// File: rtl/mc_pkg.sv
package mc_pkg;

  typedef enum logic [1:0] {
    XOR_ZERO   = 2'd0,
    XOR_ONE    = 2'd1,
    XOR_PT     = 2'd2,
    XOR_PT_ALT = 2'd3
  } xor_mode_e;

  typedef enum logic [1:0] {
    DSRC_XOR     = 2'd0,
    DSRC_PT      = 2'd1,
    DSRC_PIN     = 2'd2,
    DSRC_XOR_ALT = 2'd3
  } dsrc_e;

  typedef enum logic [2:0] {
    FF_D     = 3'd0,
    FF_T     = 3'd1,
    FF_JK    = 3'd2,
    FF_SR    = 3'd3,
    FF_LATCH = 3'd4
  } ff_mode_e;

  typedef enum logic [1:0] {
    AR_NONE   = 2'd0,
    AR_GLOBAL = 2'd1,
    AR_TERM   = 2'd2,
    AR_EITHER = 2'd3
  } ar_mode_e;

  typedef enum logic [1:0] {
    OE_ALWAYS   = 2'd0,
    OE_NEVER    = 2'd1,
    OE_TERM     = 2'd2,
    OE_TERM_ALT = 2'd3
  } oe_mode_e;

endpackage

// File: rtl/mc_term_pick.sv
module mc_term_pick #(
  parameter int NUM_PT = 5,
  localparam int IW = $clog2(NUM_PT)
) (
  input  logic [NUM_PT-1:0] pt_i,
  input  logic [IW-1:0]     idx_i,
  output logic              bit_o
);
  // out-of-range index reads as 0
  always_comb begin
    bit_o = 1'b0;
    for (int i = 0; i < NUM_PT; i++) begin
      if (idx_i == IW'(i)) bit_o = pt_i[i];
    end
  end
endmodule

// File: rtl/mc_sum_xor.sv
module mc_sum_xor
  import mc_pkg::*;
#(
  parameter int NUM_PT = 5
) (
  input  logic [NUM_PT-1:0] pt_i,
  input  logic [NUM_PT-1:0] sum_mask_i,
  input  logic              casc_en_i,
  input  logic              casc_i,
  input  xor_mode_e         xor_mode_i,
  input  logic              xor_pt_i,
  output logic              sum_o,
  output logic              comb_o
);
  logic xor_op;

  assign sum_o = (|(pt_i & sum_mask_i)) | (casc_en_i & casc_i);

  always_comb begin
    unique case (xor_mode_i)
      XOR_ZERO: xor_op = 1'b0;
      XOR_ONE:  xor_op = 1'b1;
      default:  xor_op = xor_pt_i;
    endcase
  end

  assign comb_o = sum_o ^ xor_op;
endmodule

// File: rtl/mc_storage.sv
module mc_storage
  import mc_pkg::*;
#(
  parameter int NUM_GCLK = 3,
  localparam int NSRC = NUM_GCLK + 1,
  localparam int CW = $clog2(NSRC)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_GCLK-1:0] gclk_i,
  input  logic                pt_clk_i,
  input  logic [CW-1:0]       clk_sel_i,
  input  logic                ce_i,
  input  ff_mode_e            mode_i,
  input  logic                d_i,
  input  logic                k_i,
  input  logic                ar_i,
  input  logic                ap_i,
  output logic                q_o
);
  logic [NSRC-1:0] src, src_prev_q, src_rise;
  logic            sel_ok, is_pt, lvl, rise_sel, ce_ok, nxt, state_q;

  assign src = {pt_clk_i, gclk_i};

  for (genvar g = 0; g < NSRC; g++) begin : g_edge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) src_prev_q[g] <= 1'b0;
      else         src_prev_q[g] <= src[g];
    end
    assign src_rise[g] = src[g] & ~src_prev_q[g];
  end

  assign sel_ok   = (32'(clk_sel_i) < NSRC);
  assign is_pt    = (32'(clk_sel_i) == NUM_GCLK);
  assign lvl      = sel_ok & src[clk_sel_i];
  assign rise_sel = sel_ok & src_rise[clk_sel_i];
  assign ce_ok    = is_pt | ce_i;

  always_comb begin
    unique case (mode_i)
      FF_T:    nxt = state_q ^ d_i;
      FF_JK:   nxt = (d_i & ~state_q) | (~k_i & state_q);
      FF_SR:   nxt = ~k_i & (d_i | state_q);
      default: nxt = d_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 state_q <= 1'b0;
    else if (ar_i)               state_q <= 1'b0;
    else if (ap_i)               state_q <= 1'b1;
    else if (mode_i == FF_LATCH) begin
      if (lvl && ce_ok)          state_q <= d_i;
    end
    else if (rise_sel && ce_ok)  state_q <= nxt;
  end

  // clear/set act on the output without waiting for a clock
  assign q_o = ~ar_i & (ap_i | state_q);

  a_r5_hold_without_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ar_i && !ap_i && mode_i != FF_LATCH && !(rise_sel && ce_ok)) |=> (state_q == $past(state_q)));
  a_r8_enable_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ar_i && !ap_i && !is_pt && !ce_i) |=> $stable(state_q));
  a_r9_clear_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ar_i |=> !state_q);
  a_r9_preset_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ap_i && !ar_i) |=> state_q);
  a_r7_latch_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == FF_LATCH && lvl && ce_ok && !ar_i && !ap_i) |=> (state_q == $past(d_i)));
endmodule

// File: rtl/pterm_macrocell.sv
module pterm_macrocell
  import mc_pkg::*;
#(
  parameter int NUM_PT   = 5,
  parameter int NUM_GCLK = 3,
  localparam int IW    = $clog2(NUM_PT),
  localparam int CW    = $clog2(NUM_GCLK + 1),
  localparam int CFG_W = NUM_PT + 16 + CW + 9 * IW
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [CFG_W-1:0]    cfg_i,
  input  logic [NUM_PT-1:0]   pt_i,
  input  logic                casc_i,
  input  logic [NUM_GCLK-1:0] gclk_i,
  input  logic                gclr_i,
  input  logic                pin_i,
  output logic                pin_o,
  output logic                oe_o,
  output logic                fb_o,
  output logic                casc_o,
  output logic                fold_o
);
  // configuration field offsets
  localparam int O_MASK  = 0;
  localparam int O_CEN   = O_MASK + NUM_PT;
  localparam int O_XMODE = O_CEN + 1;
  localparam int O_XIDX  = O_XMODE + 2;
  localparam int O_DSRC  = O_XIDX + IW;
  localparam int O_DIDX  = O_DSRC + 2;
  localparam int O_KIDX  = O_DIDX + IW;
  localparam int O_FFM   = O_KIDX + IW;
  localparam int O_CSEL  = O_FFM + 3;
  localparam int O_CIDX  = O_CSEL + CW;
  localparam int O_CEEN  = O_CIDX + IW;
  localparam int O_CEIDX = O_CEEN + 1;
  localparam int O_ARM   = O_CEIDX + IW;
  localparam int O_ARIDX = O_ARM + 2;
  localparam int O_APEN  = O_ARIDX + IW;
  localparam int O_APIDX = O_APEN + 1;
  localparam int O_OREG  = O_APIDX + IW;
  localparam int O_FREG  = O_OREG + 1;
  localparam int O_OEM   = O_FREG + 1;
  localparam int O_OEIDX = O_OEM + 2;
  localparam int O_FOLD  = O_OEIDX + IW;

  // product-term pick slots
  localparam int P_XOR = 0, P_D = 1, P_K = 2, P_CLK = 3, P_CE = 4;
  localparam int P_AR = 5, P_AP = 6, P_OE = 7, P_FOLD = 8, NPICK = 9;

  logic [NPICK-1:0][IW-1:0] pick_idx;
  logic [NPICK-1:0]         pick;

  assign pick_idx[P_XOR]  = cfg_i[O_XIDX  +: IW];
  assign pick_idx[P_D]    = cfg_i[O_DIDX  +: IW];
  assign pick_idx[P_K]    = cfg_i[O_KIDX  +: IW];
  assign pick_idx[P_CLK]  = cfg_i[O_CIDX  +: IW];
  assign pick_idx[P_CE]   = cfg_i[O_CEIDX +: IW];
  assign pick_idx[P_AR]   = cfg_i[O_ARIDX +: IW];
  assign pick_idx[P_AP]   = cfg_i[O_APIDX +: IW];
  assign pick_idx[P_OE]   = cfg_i[O_OEIDX +: IW];
  assign pick_idx[P_FOLD] = cfg_i[O_FOLD  +: IW];

  for (genvar p = 0; p < NPICK; p++) begin : g_pick
    mc_term_pick #(.NUM_PT(NUM_PT)) u_pick (
      .pt_i  (pt_i),
      .idx_i (pick_idx[p]),
      .bit_o (pick[p])
    );
  end

  xor_mode_e xor_mode;
  dsrc_e     dsrc;
  ff_mode_e  ff_mode;
  ar_mode_e  ar_mode;
  oe_mode_e  oe_mode;
  logic      casc_en, ce_en, ap_en, out_reg, fb_reg;
  logic      comb, d_sel, ar, ap, ce, q;

  assign xor_mode = xor_mode_e'(cfg_i[O_XMODE +: 2]);
  assign dsrc     = dsrc_e'(cfg_i[O_DSRC +: 2]);
  assign ff_mode  = ff_mode_e'(cfg_i[O_FFM +: 3]);
  assign ar_mode  = ar_mode_e'(cfg_i[O_ARM +: 2]);
  assign oe_mode  = oe_mode_e'(cfg_i[O_OEM +: 2]);
  assign casc_en  = cfg_i[O_CEN];
  assign ce_en    = cfg_i[O_CEEN];
  assign ap_en    = cfg_i[O_APEN];
  assign out_reg  = cfg_i[O_OREG];
  assign fb_reg   = cfg_i[O_FREG];

  mc_sum_xor #(.NUM_PT(NUM_PT)) u_sum (
    .pt_i       (pt_i),
    .sum_mask_i (cfg_i[O_MASK +: NUM_PT]),
    .casc_en_i  (casc_en),
    .casc_i     (casc_i),
    .xor_mode_i (xor_mode),
    .xor_pt_i   (pick[P_XOR]),
    .sum_o      (casc_o),
    .comb_o     (comb)
  );

  always_comb begin
    unique case (dsrc)
      DSRC_PT:  d_sel = pick[P_D];
      DSRC_PIN: d_sel = pin_i;
      default:  d_sel = comb;
    endcase
    unique case (ar_mode)
      AR_NONE:   ar = 1'b0;
      AR_GLOBAL: ar = gclr_i;
      AR_TERM:   ar = pick[P_AR];
      default:   ar = gclr_i | pick[P_AR];
    endcase
    unique case (oe_mode)
      OE_ALWAYS: oe_o = 1'b1;
      OE_NEVER:  oe_o = 1'b0;
      default:   oe_o = pick[P_OE];
    endcase
  end

  assign ap = ap_en & pick[P_AP];
  assign ce = ~ce_en | pick[P_CE];

  mc_storage #(.NUM_GCLK(NUM_GCLK)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .gclk_i    (gclk_i),
    .pt_clk_i  (pick[P_CLK]),
    .clk_sel_i (cfg_i[O_CSEL +: CW]),
    .ce_i      (ce),
    .mode_i    (ff_mode),
    .d_i       (d_sel),
    .k_i       (pick[P_K]),
    .ar_i      (ar),
    .ap_i      (ap),
    .q_o       (q)
  );

  assign pin_o  = out_reg ? q : comb;
  assign fb_o   = fb_reg ? q : comb;
  assign fold_o = ~pick[P_FOLD];

  a_r2_cascade_through: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (casc_en && casc_i) |-> casc_o);
  a_r9_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_reg && ar) |-> !pin_o);
endmodule

// File: tb/pterm_macrocell_bench.sv
module pterm_macrocell_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [49:0] cfg_i = '0;
  logic [4:0]  pt_i = '0;
  logic        casc_i = 1'b0;
  logic [2:0]  gclk_i = '0;
  logic        gclr_i = 1'b0;
  logic        pin_i = 1'b0;
  logic        pin_o, oe_o, fb_o, casc_o, fold_o;

  pterm_macrocell u_pterm_macrocell (
    .clk_i, .rst_ni, .cfg_i, .pt_i, .casc_i, .gclk_i, .gclr_i, .pin_i,
    .pin_o, .oe_o, .fb_o, .casc_o, .fold_o
  );

  always #10 clk_i = ~clk_i;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // configuration fields held by the bench
  logic [4:0] c_mask;
  logic       c_cen, c_ceen, c_apen, c_oreg, c_freg;
  logic [1:0] c_xmode, c_dsrc, c_csel, c_arm, c_oem;
  logic [2:0] c_xidx, c_didx, c_kidx, c_ffm, c_cidx, c_ceidx, c_aridx, c_apidx, c_oeidx, c_fold;

  // reference state
  bit       m_state;
  bit [3:0] m_prev;

  task automatic defaults();
    c_mask = 5'b11111; c_cen = 0; c_xmode = 0; c_xidx = 0; c_dsrc = 0; c_didx = 0;
    c_kidx = 0; c_ffm = 0; c_csel = 0; c_cidx = 0; c_ceen = 0; c_ceidx = 0;
    c_arm = 0; c_aridx = 0; c_apen = 0; c_apidx = 0; c_oreg = 0; c_freg = 0;
    c_oem = 0; c_oeidx = 0; c_fold = 0;
  endtask

  // R13 layout
  task automatic load_cfg();
    cfg_i = {c_fold, c_oeidx, c_oem, c_freg, c_oreg, c_apidx, c_apen, c_aridx, c_arm,
             c_ceidx, c_ceen, c_cidx, c_csel, c_ffm, c_kidx, c_didx, c_dsrc, c_xidx,
             c_xmode, c_cen, c_mask};
  endtask

  function automatic bit term(logic [2:0] idx);
    return (idx < 5) ? pt_i[idx] : 1'b0;
  endfunction

  function automatic bit m_sum();
    bit s = c_cen & casc_i;
    for (int n = 0; n < 5; n++) if (c_mask[n] && pt_i[n]) s = 1;
    return s;
  endfunction

  function automatic bit m_comb();
    bit op = (c_xmode == 0) ? 1'b0 : (c_xmode == 1) ? 1'b1 : term(c_xidx);
    return m_sum() ^ op;
  endfunction

  function automatic bit m_ar();
    case (c_arm)
      2'd0: return 1'b0;
      2'd1: return gclr_i;
      2'd2: return term(c_aridx);
      default: return gclr_i | term(c_aridx);
    endcase
  endfunction

  function automatic bit m_ap();
    return c_apen & term(c_apidx);
  endfunction

  function automatic bit m_q();
    if (m_ar()) return 1'b0;
    if (m_ap()) return 1'b1;
    return m_state;
  endfunction

  function automatic bit m_data();
    case (c_dsrc)
      2'd1: return term(c_didx);
      2'd2: return pin_i;
      default: return m_comb();
    endcase
  endfunction

  task automatic chk(string tag, string what, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b", tag, what, got, exp);
    end
  endtask

  task automatic compare(string tag);
    bit comb = m_comb();
    bit q = m_q();
    bit oe = (c_oem == 0) ? 1'b1 : (c_oem == 1) ? 1'b0 : term(c_oeidx);
    chk(tag, "casc_o", casc_o, m_sum());
    chk(tag, "pin_o", pin_o, c_oreg ? q : comb);
    chk(tag, "fb_o", fb_o, c_freg ? q : comb);
    chk(tag, "oe_o", oe_o, oe);
    chk(tag, "fold_o", fold_o, ~term(c_fold));
  endtask

  task automatic model_update();
    bit [3:0] src = {term(c_cidx), gclk_i};
    bit lvl = src[c_csel];
    bit rise = lvl && !m_prev[c_csel];
    bit ce_ok = (c_csel == 3) ? 1'b1 : (!c_ceen || term(c_ceidx));
    bit d = m_data();
    bit k = term(c_kidx);
    bit nx = m_state;
    if (m_ar()) nx = 0;
    else if (m_ap()) nx = 1;
    else if (c_ffm == 4) begin
      if (lvl && ce_ok) nx = d;
    end else if (rise && ce_ok) begin
      case (c_ffm)
        3'd1: nx = m_state ^ d;
        3'd2: nx = (d && k) ? !m_state : d ? 1'b1 : k ? 1'b0 : m_state;
        3'd3: nx = k ? 1'b0 : d ? 1'b1 : m_state;
        default: nx = d;
      endcase
    end
    m_state = nx;
    m_prev = src;
  endtask

  // apply at negedge, compare mid low phase, then advance the model
  task automatic run(string tag, int n);
    load_cfg();
    for (int i = 0; i < n; i++) begin
      pt_i = 5'($urandom);
      casc_i = 1'($urandom);
      gclk_i = 3'($urandom);
      gclr_i = ($urandom % 4) == 0;
      pin_i = 1'($urandom);
      #5;
      compare(tag);
      model_update();
      @(negedge clk_i);
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    defaults();
    c_oreg = 1; c_freg = 1;
    load_cfg();
    m_state = 0; m_prev = '0;
    repeat (3) @(negedge clk_i);
    #5;
    chk("R12", "pin_o in reset", pin_o, 1'b0);
    chk("R12", "fb_o in reset", fb_o, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #5;
    chk("R12", "pin_o after reset", pin_o, 1'b0);
    @(negedge clk_i);
    model_update();

    defaults(); c_mask = 5'b10110;                  run("R1", 30);
    defaults(); c_mask = 5'b00000;                  run("R1", 10);
    defaults(); c_mask = 5'b00001; c_cen = 1;       run("R2", 30);
    defaults(); c_mask = 5'b00001; c_cen = 0;       run("R2", 20);
    defaults(); c_xmode = 0;                        run("R3", 15);
    defaults(); c_xmode = 1;                        run("R3", 15);
    defaults(); c_xmode = 2; c_xidx = 3;            run("R3", 15);
    defaults(); c_xmode = 3; c_xidx = 1; c_mask = 5'b00100; run("R3", 15);
    defaults(); c_oreg = 1; c_dsrc = 1; c_didx = 2; run("R4", 40);
    defaults(); c_oreg = 1; c_dsrc = 2;             run("R4", 40);
    defaults(); c_oreg = 1; c_dsrc = 0; c_mask = 5'b01010; run("R4", 40);
    defaults(); c_oreg = 1; c_ffm = 1; c_csel = 1; c_dsrc = 1; c_didx = 4; run("R5", 50);
    defaults(); c_oreg = 1; c_ffm = 6; c_csel = 0;  run("R5", 30);
    defaults(); c_oreg = 1; c_ffm = 2; c_csel = 2; c_dsrc = 1; c_didx = 0; c_kidx = 1; run("R6", 60);
    defaults(); c_oreg = 1; c_ffm = 3; c_csel = 2; c_dsrc = 1; c_didx = 0; c_kidx = 1; run("R6", 60);
    defaults(); c_oreg = 1; c_ffm = 4; c_csel = 0; c_dsrc = 2; run("R7", 50);
    defaults(); c_oreg = 1; c_ffm = 4; c_csel = 1; c_dsrc = 2; c_ceen = 1; c_ceidx = 3; run("R7", 40);
    defaults(); c_oreg = 1; c_csel = 3; c_cidx = 4; c_dsrc = 2; run("R8", 50);
    defaults(); c_oreg = 1; c_csel = 0; c_ceen = 1; c_ceidx = 3; c_dsrc = 2; run("R8", 50);
    defaults(); c_oreg = 1; c_csel = 3; c_cidx = 2; c_ceen = 1; c_ceidx = 0; c_dsrc = 2; run("R8", 50);
    defaults(); c_oreg = 1; c_dsrc = 2; c_arm = 1;  run("R9", 40);
    defaults(); c_oreg = 1; c_dsrc = 2; c_arm = 2; c_aridx = 1; run("R9", 40);
    defaults(); c_oreg = 1; c_dsrc = 2; c_arm = 3; c_aridx = 1; c_apen = 1; c_apidx = 2; run("R9", 60);
    defaults(); c_oreg = 1; c_dsrc = 2; c_apen = 1; c_apidx = 4; run("R9", 40);
    defaults(); c_oreg = 0; c_freg = 1; c_dsrc = 2; run("R10", 40);
    defaults(); c_oreg = 1; c_freg = 0; c_dsrc = 2; run("R10", 40);
    defaults(); c_oem = 0; c_fold = 2;              run("R11", 15);
    defaults(); c_oem = 1; c_fold = 4;              run("R11", 15);
    defaults(); c_oem = 2; c_oeidx = 3; c_fold = 0; run("R11", 15);
    defaults(); c_oem = 3; c_oeidx = 4; c_fold = 1; run("R11", 15);
    defaults(); c_xmode = 2; c_xidx = 7; c_oem = 2; c_oeidx = 6; c_fold = 5;
    c_oreg = 1; c_csel = 3; c_cidx = 7; c_dsrc = 2; run("R12", 40);
    defaults(); c_mask = 5'b10000; c_fold = 4; c_oem = 2; c_oeidx = 4;
    c_freg = 1; c_ffm = 1; c_csel = 2; c_apen = 1; c_apidx = 3; run("R13", 40);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule